// File: doc/BRIEF.md
# Register Stack Push/Pop Engine

This block runs single-byte stack instructions against its own file of eight 32-bit registers and an external byte-wide memory. Entry 4 of the register file is the stack pointer. A push lowers the stack pointer by four. It then stores the chosen register as a word at the new top of stack. A pop reads the word at the current top into the chosen register. It then raises the stack pointer by four.

A caller presents an opcode together with a one-cycle `start`. The engine moves the four bytes of the word over the memory port in four consecutive cycles, lowest address first. It then pulses `done` for one cycle. A separate write port and a combinational read port let the surrounding datapath load and inspect the registers while the engine is idle. No condition flags exist in this block, and none change.

Top module: `stack_engine`

## Requirements
- R1: An opcode is accepted only when `start` is high while the engine is idle and the opcode's upper nibble is 0x5. Any other opcode causes no busy cycle, no memory strobe and no `done`, and changes no register.
- R2: A push (opcodes 0x50 to 0x57) lowers register 4 by 4 on the accepting edge. It then writes the register chosen by opcode bits 2:0 to the four byte addresses new_SP+0 to new_SP+3. Bits 7:0 go to the lowest address and bits 31:24 to the highest (little-endian).
- R3: A pop (opcodes 0x58 to 0x5F) reads the four byte addresses SP+0 to SP+3 in little-endian order. It places the assembled word in the register chosen by opcode bits 2:0.
- R4: A pop into any register other than register 4 leaves register 4 equal to its value at acceptance plus 4.
- R5: A push of register 4 (opcode 0x54) stores the stack-pointer value from before the decrement.
- R6: A pop into register 4 (opcode 0x5C) leaves register 4 holding the loaded word, with no increment.
- R7: The four byte transfers take the four cycles that follow acceptance. `done` is high for exactly one cycle, the cycle after the last transfer, so it appears on the fifth cycle after the accepting edge.
- R8: `start` is ignored while `busy` is high.
- R9: The register write port updates the indexed register on a clock edge only when the engine is idle and no opcode is accepted on that edge. The read port shows the indexed register without delay.
- R10: Reset clears all registers to zero, makes the engine idle, and holds `done`, `mem_we` and `mem_re` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run `opcode` |
| opcode | input | 8 | Instruction byte |
| busy | output | 1 | Engine is running an instruction |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 32 | Byte address of the current transfer |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the same cycle as the address |
| reg_we | input | 1 | Register file write enable |
| reg_wr_idx | input | 3 | Register to write |
| reg_wr_data | input | 32 | Value to write |
| reg_rd_idx | input | 3 | Register to read |
| reg_rd_data | output | 32 | Value of register `reg_rd_idx` |

## Verification
The hardest case to reach is a pop into the stack pointer. For that case the memory must already hold a word different from the old pointer plus four, and the bench has no backdoor into memory. The stimulus first loads a marker value into register 1 and pushes it. It then issues opcode 0x5C against that slot. With this setup, a suppressed increment and a wrongly applied one give different results. A second situation is a new request and a register write arriving in the middle of a transfer. The bench raises both on the cycle after a push is accepted, then checks that the stack pointer moved only once and that the target register is unchanged.

// File: rtl/stack_engine.sv
module stack_engine #(
  parameter int XLEN   = 32,
  parameter int NREG   = 8,
  parameter int SP_IDX = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [7:0]              opcode,
  output logic                    busy,
  output logic                    done,
  output logic [XLEN-1:0]         mem_addr,
  output logic                    mem_we,
  output logic                    mem_re,
  output logic [7:0]              mem_wdata,
  input  logic [7:0]              mem_rdata,
  input  logic                    reg_we,
  input  logic [$clog2(NREG)-1:0] reg_wr_idx,
  input  logic [XLEN-1:0]         reg_wr_data,
  input  logic [$clog2(NREG)-1:0] reg_rd_idx,
  output logic [XLEN-1:0]         reg_rd_data
);
  localparam int BYTES = XLEN / 8;
  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(BYTES);
  localparam logic [XLEN-1:0]  STEP = XLEN'(BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             is_pop;
  logic [IDX_W-1:0] sel;
  logic [XLEN-1:0]  base;
  logic [XLEN-1:0]  word;
  logic [XLEN-1:0]  rf [NREG];

  wire              accept  = (state == S_IDLE) && start && (opcode[7:4] == 4'h5);
  wire [IDX_W-1:0]  sel_in  = opcode[IDX_W-1:0];
  wire [XLEN-1:0]   sp      = rf[SP_IDX];
  wire [XLEN-1:0]   shamt   = XLEN'({cnt, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      is_pop <= 1'b0;
      sel    <= '0;
      base   <= '0;
      word   <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            state  <= S_XFER;
            cnt    <= '0;
            sel    <= sel_in;
            is_pop <= opcode[3];
            if (opcode[3]) begin
              base <= sp;
              word <= '0;
            end else begin
              base        <= sp - STEP;
              word        <= rf[sel_in];
              rf[SP_IDX]  <= sp - STEP;
            end
          end else if (reg_we) begin
            rf[reg_wr_idx] <= reg_wr_data;
          end
        end
        S_XFER: begin
          cnt <= cnt + 1'b1;
          if (is_pop) word <= word | (XLEN'(mem_rdata) << shamt);
          if (cnt == LAST) begin
            state <= S_DONE;
            if (is_pop) begin
              if (sel != IDX_W'(SP_IDX)) rf[SP_IDX] <= base + STEP;
              rf[sel] <= word | (XLEN'(mem_rdata) << shamt);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state != S_IDLE);
  assign done        = (state == S_DONE);
  assign mem_we      = (state == S_XFER) && !is_pop;
  assign mem_re      = (state == S_XFER) && is_pop;
  assign mem_addr    = base + XLEN'(cnt);
  assign mem_wdata   = 8'(word >> shamt);
  assign reg_rd_data = rf[reg_rd_idx];

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we || mem_re));
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we || mem_re) && $past(mem_we || mem_re)) |-> (mem_addr == $past(mem_addr) + 1));
  p_push_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !opcode[3]) |=> (rf[SP_IDX] == $past(sp) - STEP));
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/stack_engine_tb_top.sv
module stack_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        busy, done, mem_we, mem_re;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_wr_idx = 3'd0;
  logic [31:0] reg_wr_data = 32'd0;
  logic [2:0]  reg_rd_idx = 3'd0;
  logic [31:0] reg_rd_data;

  logic [7:0]  mem [256];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[7:0]];

  stack_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .reg_we(reg_we), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data)
  );

  // {opcode, expected SP afterwards, pushed word or popped value}
  localparam logic [71:0] VEC [6] = '{
    {8'h53, 32'h60, 32'h0000000A},
    {8'h50, 32'h5C, 32'hA1B2C3D4},
    {8'h57, 32'h58, 32'hDEADBEEF},
    {8'h5B, 32'h5C, 32'hDEADBEEF},
    {8'h59, 32'h60, 32'hA1B2C3D4},
    {8'h5E, 32'h64, 32'h0000000A}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a[7:0]]};
  endfunction

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    reg_rd_idx = idx;
    #1 v = reg_rd_data;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wr_idx = idx; reg_wr_data = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic run_op(input logic [7:0] op, output int cyc, output int nwe, output int nre);
    @(negedge clk); start = 1'b1; opcode = op;
    @(negedge clk); start = 1'b0;
    cyc = 1; nwe = 0; nre = 0;
    while (!done && cyc < 20) begin
      nwe += int'(mem_we); nre += int'(mem_re);
      @(negedge clk); cyc++;
    end
    @(negedge clk);
    chk(!done, "R7 done lasts one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd5000, 32'd0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc, nwe, nre;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !mem_we && !mem_re, "R10 idle outputs in reset",
        {28'd0, busy, done, mem_we, mem_re}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk(v == 32'd0, "R10 register cleared", v, 32'd0);
    end

    wr(3'd3, 32'h0000000A);
    wr(3'd4, 32'h00000064);
    wr(3'd0, 32'hA1B2C3D4);
    wr(3'd7, 32'hDEADBEEF);
    rd(3'd3, v); chk(v == 32'h0A, "R9 register write and read", v, 32'h0A);

    for (int k = 0; k < 6; k++) begin
      logic [7:0] op; logic [31:0] esp, eval;
      {op, esp, eval} = VEC[k];
      run_op(op, cyc, nwe, nre);
      chk(cyc == 5, "R7 done on fifth cycle", 32'(cyc), 32'd5);
      rd(3'd4, v);
      if (!op[3]) begin
        chk(nwe == 4 && nre == 0, "R2 push makes four byte writes", 32'(nwe), 32'd4);
        chk(v == esp, "R2 push lowers SP by 4", v, esp);
        chk(mword(esp) == eval, "R2 pushed word in memory", mword(esp), eval);
      end else begin
        chk(nre == 4 && nwe == 0, "R3 pop makes four byte reads", 32'(nre), 32'd4);
        chk(v == esp, "R4 pop raises SP by 4", v, esp);
        rd(op[2:0], v);
        chk(v == eval, "R3 popped word in register", v, eval);
      end
    end
    chk(mem[8'h5C] == 8'hD4, "R2 low byte at lowest address", 32'(mem[8'h5C]), 32'hD4);
    chk(mem[8'h5F] == 8'hA1, "R2 high byte at highest address", 32'(mem[8'h5F]), 32'hA1);

    // R5 push of the stack pointer stores its old value
    run_op(8'h54, cyc, nwe, nre);
    rd(3'd4, v); chk(v == 32'h60, "R5 SP after pushing SP", v, 32'h60);
    chk(mword(32'h60) == 32'h64, "R5 stored pre-decrement SP", mword(32'h60), 32'h64);

    // R6 pop into the stack pointer keeps the loaded value
    wr(3'd1, 32'h00000080);
    run_op(8'h51, cyc, nwe, nre);
    run_op(8'h5C, cyc, nwe, nre);
    rd(3'd4, v); chk(v == 32'h80, "R6 SP holds popped word", v, 32'h80);

    // R1 foreign opcodes are ignored
    foreach (VEC[k]) begin end
    for (int j = 0; j < 3; j++) begin
      logic [7:0] bad;
      int act;
      bad = (j == 0) ? 8'h90 : (j == 1) ? 8'h60 : 8'h4F;
      act = 0;
      @(negedge clk); start = 1'b1; opcode = bad;
      @(negedge clk); start = 1'b0;
      for (int c = 0; c < 6; c++) begin
        act += int'(busy) + int'(done) + int'(mem_we) + int'(mem_re);
        @(negedge clk);
      end
      chk(act == 0, "R1 foreign opcode causes no activity", 32'(act), 32'd0);
      rd(3'd4, v); chk(v == 32'h80, "R1 SP unchanged by foreign opcode", v, 32'h80);
    end

    // R8 / R9 requests during a transfer are ignored
    wr(3'd7, 32'h77777777);
    wr(3'd2, 32'h22222222);
    @(negedge clk); start = 1'b1; opcode = 8'h57;
    @(negedge clk); opcode = 8'h5A; reg_we = 1'b1; reg_wr_idx = 3'd2; reg_wr_data = 32'h99;
    @(negedge clk); start = 1'b0; reg_we = 1'b0;
    for (int c = 0; c < 10 && !done; c++) @(negedge clk);
    repeat (8) @(negedge clk);
    rd(3'd4, v); chk(v == 32'h7C, "R8 start during busy ignored", v, 32'h7C);
    rd(3'd2, v); chk(v == 32'h22222222, "R9 write during busy ignored", v, 32'h22222222);
    chk(mword(32'h7C) == 32'h77777777, "R8 first push completed", mword(32'h7C), 32'h77777777);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule